// File: doc/BRIEF.md
# Burst Read Engine for Memory Port

This block pulls image data out of an external memory controller port and hands it to an encoder's input buffer in fixed-size bursts. It waits after reset until the memory reports calibration complete. From then on, whenever a frame sequencer holds its read-enable flag high, the engine pushes one read command with an address into the port's command FIFO. It then waits until the port's read-data FIFO holds the entire burst, and moves that burst word by word into the encoder buffer, pausing on every cycle in which the buffer reports full.

The first command of a frame uses the base address sampled when read-enable is seen high in the idle state. Each later command advances that address by one burst's worth of bytes. After a configured number of bursts the engine raises a one-cycle completion pulse and stays quiet until the sequencer drops read-enable and raises it again. Read data reaches the buffer in the same cycle it is popped. There is no extra register stage, so no storage is needed beyond the port FIFO.

Top module: `burst_rd_engine`

## Requirements
- R1: While the engine has not yet seen `calib_done_i` high since reset, `cmd_en_o` stays low, even with `rd_en_i` high.
- R2: `cmd_en_o` is high only when `rd_en_i` is high and `cmd_full_i` is low. It is a single-cycle strobe, and there is no second command before the current burst has been fully forwarded.
- R3: No word of a burst is popped until `rdf_count_i` reports at least BURST_LEN (default 64) words.
- R4: `rdf_pop_o` and `buf_wr_o` are high only when `buf_full_i` is low. They are always equal, and `buf_data_o` equals `rdf_data_i` in the same cycle.
- R5: Exactly BURST_LEN words are popped per command. In the cycle after the last pop of a burst that is not the frame's last, the engine is ready to issue the next command.
- R6: The first command of a frame carries the `base_addr_i` value present when the engine leaves idle. Each following command adds BURST_LEN*DATA_W/8 bytes (default 256).
- R7: `frame_done_o` is high for exactly one cycle: the cycle after the last pop of burst number FRAME_BURSTS (default 4). No command follows it until `rd_en_i` has gone low and high again.
- R8: If `rd_en_i` drops while a command is waiting to be issued, no command is issued and the engine returns to idle. The next rise of `rd_en_i` restarts at the new base address.
- R9: Out of reset, `cmd_en_o`, `rdf_pop_o`, `buf_wr_o` and `frame_done_o` are low and `cmd_addr_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| calib_done_i | input | 1 | Memory calibration complete |
| rd_en_i | input | 1 | Frame read-enable from the sequencer |
| base_addr_i | input | ADDR_W | Frame base byte address |
| cmd_full_i | input | 1 | Command FIFO full |
| cmd_en_o | output | 1 | Read command push strobe |
| cmd_addr_o | output | ADDR_W | Byte address of the burst |
| rdf_count_i | input | CNT_W | Words held in the read-data FIFO |
| rdf_data_i | input | DATA_W | Read-data FIFO head word |
| rdf_pop_o | output | 1 | Read-data FIFO pop |
| buf_full_i | input | 1 | Encoder buffer full |
| buf_wr_o | output | 1 | Encoder buffer write |
| buf_data_o | output | DATA_W | Word written to the encoder buffer |
| frame_done_o | output | 1 | One-cycle pulse after the last burst of a frame |

## Verification
On every cycle the assertions check the following. No command goes out before calibration has been seen, or without read-enable and command-FIFO space. Commands are single-cycle. No pop happens into a full buffer, and the first pop of a burst never comes with fewer than a burst of words present. Completion is a single pulse, and the engine is back at the command stage after a non-final burst. The address sequence, the exact number of words and their order per burst, and the frame-restart rules after completion or abort can only be shown by the bench's scenarios. Those scenarios vary buffer back-pressure, command-FIFO stalls and fill delays.

// File: rtl/brd_pkg.sv
package brd_pkg;
  typedef enum logic [2:0] {
    ST_CAL,
    ST_IDLE,
    ST_CMD,
    ST_WAIT,
    ST_DRAIN,
    ST_FIN
  } brd_state_e;
endpackage

// File: rtl/brd_addr_gen.sv
module brd_addr_gen #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned STEP_BYTES = 256
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              adv_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(STEP_BYTES);

  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_q <= '0;
    else if (load_i) addr_q <= base_i;
    else if (adv_i)  addr_q <= addr_q + STEP;
  end

  assign addr_o = addr_q;

  // load and advance never coincide: load happens leaving idle, advance in command state
  assert_no_load_adv_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(load_i && adv_i));
endmodule

// File: rtl/brd_beat_cnt.sv
module brd_beat_cnt #(
  parameter int unsigned BURST_LEN    = 64,
  parameter int unsigned FRAME_BURSTS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic pop_i,
  output logic first_beat_o,
  output logic last_beat_o,
  output logic last_burst_o
);
  localparam int unsigned BEAT_W  = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;
  localparam int unsigned BURST_W = (FRAME_BURSTS > 1) ? $clog2(FRAME_BURSTS) : 1;
  localparam logic [BEAT_W-1:0]  BEAT_MAX  = BEAT_W'(BURST_LEN - 1);
  localparam logic [BURST_W-1:0] BURST_MAX = BURST_W'(FRAME_BURSTS - 1);

  logic [BEAT_W-1:0]  beat_q;
  logic [BURST_W-1:0] burst_q;

  assign first_beat_o = (beat_q == '0);
  assign last_beat_o  = (beat_q == BEAT_MAX);
  assign last_burst_o = (burst_q == BURST_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      beat_q  <= '0;
      burst_q <= '0;
    end else if (clear_i) begin
      beat_q  <= '0;
      burst_q <= '0;
    end else if (pop_i) begin
      if (last_beat_o) begin
        beat_q  <= '0;
        burst_q <= last_burst_o ? '0 : burst_q + 1'b1;
      end else begin
        beat_q <= beat_q + 1'b1;
      end
    end
  end

  // beat counter wraps to zero exactly after a full burst
  assert_beat_wrap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !clear_i && last_beat_o) |=> first_beat_o);
endmodule

// File: rtl/brd_fsm.sv
module brd_fsm
  import brd_pkg::*;
#(
  parameter int unsigned BURST_LEN = 64,
  parameter int unsigned CNT_W     = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             calib_done_i,
  input  logic             rd_en_i,
  input  logic             cmd_full_i,
  input  logic [CNT_W-1:0] rdf_count_i,
  input  logic             buf_full_i,
  input  logic             last_beat_i,
  input  logic             last_burst_i,
  output logic             start_o,
  output logic             cmd_en_o,
  output logic             pop_o,
  output logic             frame_done_o
);
  localparam logic [CNT_W-1:0] FILL_MARK = CNT_W'(BURST_LEN);

  brd_state_e state_q, state_d;
  logic       done_q;
  logic       burst_ready;
  logic       burst_end;

  assign burst_ready = (rdf_count_i >= FILL_MARK);
  assign start_o     = (state_q == ST_IDLE) && rd_en_i;
  assign cmd_en_o    = (state_q == ST_CMD) && rd_en_i && !cmd_full_i;
  assign pop_o       = (state_q == ST_DRAIN) && !buf_full_i;
  assign burst_end   = pop_o && last_beat_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_CAL:   if (calib_done_i) state_d = ST_IDLE;
      ST_IDLE:  if (rd_en_i) state_d = ST_CMD;
      ST_CMD: begin
        if (!rd_en_i)     state_d = ST_IDLE;
        else if (cmd_en_o) state_d = ST_WAIT;
      end
      ST_WAIT:  if (burst_ready) state_d = ST_DRAIN;
      ST_DRAIN: if (burst_end) state_d = last_burst_i ? ST_FIN : ST_CMD;
      ST_FIN:   if (!rd_en_i) state_d = ST_IDLE;
      default:  state_d = ST_CAL;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_CAL;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= burst_end && last_burst_i;
    end
  end

  assign frame_done_o = done_q;

  assert_next_cmd_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_o && last_beat_i && !last_burst_i) |=> (state_q == ST_CMD));

  assert_fin_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |-> !cmd_en_o && !pop_o);

  assert_abort_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CMD && !rd_en_i) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/burst_rd_engine.sv
module burst_rd_engine #(
  parameter int unsigned ADDR_W       = 32,
  parameter int unsigned DATA_W       = 32,
  parameter int unsigned BURST_LEN    = 64,
  parameter int unsigned RDF_DEPTH    = 64,
  parameter int unsigned FRAME_BURSTS = 4,
  localparam int unsigned CNT_W       = $clog2(RDF_DEPTH + 1),
  localparam int unsigned STEP_BYTES  = BURST_LEN * (DATA_W / 8)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              calib_done_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] base_addr_i,
  input  logic              cmd_full_i,
  output logic              cmd_en_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  input  logic [CNT_W-1:0]  rdf_count_i,
  input  logic [DATA_W-1:0] rdf_data_i,
  output logic              rdf_pop_o,
  input  logic              buf_full_i,
  output logic              buf_wr_o,
  output logic [DATA_W-1:0] buf_data_o,
  output logic              frame_done_o
);
  logic start, pop, first_beat, last_beat, last_burst;

  brd_fsm #(
    .BURST_LEN (BURST_LEN),
    .CNT_W     (CNT_W)
  ) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .calib_done_i (calib_done_i),
    .rd_en_i      (rd_en_i),
    .cmd_full_i   (cmd_full_i),
    .rdf_count_i  (rdf_count_i),
    .buf_full_i   (buf_full_i),
    .last_beat_i  (last_beat),
    .last_burst_i (last_burst),
    .start_o      (start),
    .cmd_en_o     (cmd_en_o),
    .pop_o        (pop),
    .frame_done_o (frame_done_o)
  );

  brd_addr_gen #(
    .ADDR_W     (ADDR_W),
    .STEP_BYTES (STEP_BYTES)
  ) u_addr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (start),
    .base_i (base_addr_i),
    .adv_i  (cmd_en_o),
    .addr_o (cmd_addr_o)
  );

  brd_beat_cnt #(
    .BURST_LEN    (BURST_LEN),
    .FRAME_BURSTS (FRAME_BURSTS)
  ) u_cnt (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clear_i      (start),
    .pop_i        (pop),
    .first_beat_o (first_beat),
    .last_beat_o  (last_beat),
    .last_burst_o (last_burst)
  );

  assign rdf_pop_o  = pop;
  assign buf_wr_o   = pop;
  assign buf_data_o = rdf_data_i;

  // checker state: calibration observed since reset
  logic cal_seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cal_seen_q <= 1'b0;
    else if (calib_done_i) cal_seen_q <= 1'b1;
  end

  assert_no_cmd_precal_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_en_o |-> cal_seen_q);

  assert_cmd_gated_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_en_o |-> (rd_en_i && !cmd_full_i));

  assert_cmd_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_en_o |=> !cmd_en_o);

  assert_full_burst_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdf_pop_o && first_beat) |-> (rdf_count_i >= CNT_W'(BURST_LEN)));

  assert_no_overflow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_wr_o |-> !buf_full_i);

  assert_done_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |=> !frame_done_o);
endmodule

// File: tb/burst_rd_engine_test.sv
module burst_rd_engine_test;
  localparam int unsigned AW = 32;
  localparam int unsigned DW = 32;
  localparam int unsigned BL = 64;
  localparam int unsigned NB = 4;
  localparam int unsigned CW = 7;
  localparam logic [AW-1:0] STEP = 32'd256;

  // per burst: [23:16] buffer-full period (0 = never), [15:8] cmd-full cycles, [7:0] fill wait
  localparam logic [23:0] VEC [NB] = '{24'h00_00_03, 24'h02_04_0A, 24'h03_00_00, 24'h05_02_14};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic calib = 1'b0, rd_en = 1'b0, cmd_full = 1'b0, buf_full = 1'b0;
  logic [AW-1:0] base = '0;
  logic [CW-1:0] rdf_count = '0;
  logic [DW-1:0] rdf_data = '0;
  logic cmd_en, rdf_pop, buf_wr, frame_done;
  logic [AW-1:0] cmd_addr;
  logic [DW-1:0] buf_data;

  int checks = 0, fails = 0;
  bit timed_out = 0;

  always #4 clk = ~clk;

  burst_rd_engine #(.ADDR_W(AW), .DATA_W(DW), .BURST_LEN(BL), .RDF_DEPTH(64), .FRAME_BURSTS(NB)) uut (
    .clk_i(clk), .rst_ni(rst_n), .calib_done_i(calib), .rd_en_i(rd_en), .base_addr_i(base),
    .cmd_full_i(cmd_full), .cmd_en_o(cmd_en), .cmd_addr_o(cmd_addr), .rdf_count_i(rdf_count),
    .rdf_data_i(rdf_data), .rdf_pop_o(rdf_pop), .buf_full_i(buf_full), .buf_wr_o(buf_wr),
    .buf_data_o(buf_data), .frame_done_o(frame_done));

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // one burst: wait for command, fill FIFO, drain under back-pressure
  task automatic run_burst(input logic [AW-1:0] exp_addr, input logic [23:0] v, input bit last);
    int busy = int'(v[15:8]);
    int fillw = int'(v[7:0]);
    int per = int'(v[23:16]);
    int words = 0;
    int k = 0;
    bit got = 0, bad_gate = 0, early = 0, bad_full = 0, bad_data = 0, extra_cmd = 0;
    logic [AW-1:0] addr_seen = '0;
    rdf_count = '0;
    buf_full = 1'b0;
    for (int i = 0; i < 200 && !got; i++) begin
      cmd_full = (i < busy);
      #1;
      if (cmd_en) begin
        got = 1;
        addr_seen = cmd_addr;
        if (cmd_full || !rd_en) bad_gate = 1;
      end
      tick();
    end
    cmd_full = 1'b0;
    check(got && !bad_gate, "R2 command issued with rd_en high and cmd FIFO not full", got, 1);
    check(addr_seen == exp_addr, "R6 burst address", addr_seen, exp_addr);
    for (int i = 0; i < fillw; i++) begin
      rdf_count = CW'((i < BL - 1) ? i : BL - 1);
      #1;
      if (rdf_pop) early = 1;
      if (cmd_en) extra_cmd = 1;
      tick();
    end
    rdf_count = CW'(BL - 1);
    #1;
    if (rdf_pop) early = 1;
    tick();
    check(!early, "R3 no pop before full burst present", early, 0);
    while (words < BL && k < 2000) begin
      buf_full = (per != 0) && ((k % per) == 0);
      rdf_count = CW'(BL - words);
      rdf_data = 32'hA500_0000 + DW'(words);
      #1;
      if (rdf_pop !== buf_wr) bad_full = 1;
      if (rdf_pop && buf_full) bad_full = 1;
      if (cmd_en) extra_cmd = 1;
      if (rdf_pop) begin
        if (buf_data !== rdf_data) bad_data = 1;
        words++;
      end
      k++;
      tick();
    end
    buf_full = 1'b0;
    rdf_count = '0;
    check(!bad_full, "R4 pop and write only when buffer not full", bad_full, 0);
    check(!bad_data, "R4 data passes through in pop cycle", bad_data, 0);
    check(words == BL && !extra_cmd, "R2 one command per burst of 64 pops", words, BL);
    #1;
    check(!rdf_pop, "R5 no pop beyond burst length", rdf_pop, 0);
    if (!last) check(cmd_en && !frame_done, "R5 next command ready after burst", cmd_en, 1);
    else check(frame_done && !cmd_en, "R7 frame done pulse after last burst", frame_done, 1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    timed_out = 1;
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    bit seen;
    repeat (3) tick();
    #1;
    check(!cmd_en && !rdf_pop && !buf_wr && !frame_done && cmd_addr == '0,
          "R9 reset state", {cmd_en, rdf_pop, buf_wr, frame_done}, 0);
    rst_n = 1'b1;
    base = 32'h0000_1000;
    rd_en = 1'b1;
    seen = 0;
    for (int i = 0; i < 12; i++) begin
      tick(); #1;
      if (cmd_en) seen = 1;
    end
    check(!seen, "R1 no command before calibration", seen, 0);
    tick();
    calib = 1'b1;
    tick();
    calib = 1'b0;  // level only needs to be seen once

    for (int b = 0; b < int'(NB); b++)
      run_burst(32'h0000_1000 + STEP * AW'(b), VEC[b], b == int'(NB) - 1);

    tick(); #1;
    check(!frame_done, "R7 frame done lasts one cycle", frame_done, 0);
    seen = 0;
    for (int i = 0; i < 10; i++) begin
      tick(); #1;
      if (cmd_en) seen = 1;
    end
    check(!seen, "R7 no command after frame until rd_en re-raised", seen, 0);

    rd_en = 1'b0;
    base = 32'h0000_8000;
    tick(); tick();
    rd_en = 1'b1;
    tick();
    run_burst(32'h0000_8000, 24'h00_00_01, 1'b0);

    // now waiting to issue second command; block it and abort
    cmd_full = 1'b1;
    tick();
    rd_en = 1'b0;
    seen = 0;
    for (int i = 0; i < 4; i++) begin
      cmd_full = 1'b0;
      #1;
      if (cmd_en) seen = 1;
      tick();
    end
    check(!seen, "R8 no command while rd_en low", seen, 0);
    base = 32'h0000_2000;
    rd_en = 1'b1;
    tick();
    run_burst(32'h0000_2000, 24'h00_00_02, 1'b0);
    rd_en = 1'b0;
    tick(); tick();

    if (!timed_out) begin
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule